// File: doc/BRIEF.md
# Eight-Pin GPIO Port with One-Byte Mailbox

This block is an eight-pin general purpose I/O port on a simple register bus. Software can drive, sample and set the direction of the pins one at a time, or treat all eight as one byte. Each pin has a direction bit, and inputs pass through a two-flop synchroniser before software sees them.

Each direction of the port can also run as a one-byte mailbox. When latched input is selected, an external capture strobe copies the synchronised pins into a holding byte and raises a full flag. A processor read drains the byte and clears the flag. When latched output is selected, a processor write loads the output byte and clears an empty flag, and an external acknowledge strobe marks the byte as taken and sets empty again. When transparent mode is selected, reads return the live synchronised pins and the strobes have no effect. The full and empty flags can each be enabled to drive a level-sensitive interrupt request.

Top module: `gpio_mailbox_port`

## Requirements
- R1: After reset all pins are inputs (pin_oe = 0x00), pin_out = 0x00, full = 0, empty = 1, the mode byte is 0x00 and irq = 0.
- R2: A byte write to address 0x0 (data) appears on pin_out at the next clock. A byte write to address 0x1 (direction, 1 = output) appears on pin_oe at the next clock.
- R3: A write to address 0x8+i sets pin i's output bit from wdata[0] and its direction bit from wdata[1], and leaves the other seven bits of both unchanged. A read of 0x8+i returns the direction bit in bit 1 and the synchronised input in bit 0.
- R4: In transparent input mode (mode bit 0 = 0), a read of address 0x0 returns a pin value two clock edges after it was applied, and not after only one edge. cap_stb is ignored and full stays 0.
- R5: In latched input mode (mode bit 0 = 1), cap_stb copies the synchronised pins into the holding byte and sets full. Reads of address 0x0 then return that byte even after the pins change.
- R6: In latched input mode, a read of address 0x0 clears full at the next clock. If cap_stb arrives in the same cycle as the read, full stays set and the new byte is held.
- R7: In latched output mode (mode bit 1 = 1), a write to address 0x0 clears empty and take_ack sets it. A write and take_ack in the same cycle leave empty clear. In transparent output mode, writes and take_ack leave empty unchanged.
- R8: Address 0x2 reads back the mode byte: bit 0 latched input, bit 1 latched output, bit 2 full interrupt enable, bit 3 empty interrupt enable. Address 0x3 reads status: bit 0 full, bit 1 empty, bit 2 irq.
- R9: irq = (full AND full enable) OR (empty AND empty enable). It follows the flags in the same cycle and drops when the causing flag clears or its enable is removed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register or pin address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from state and address |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Output levels to the pads |
| pin_oe | output | 8 | Per-pin output enable, 1 = drive |
| cap_stb | input | 1 | External strobe that captures an input byte |
| take_ack | input | 1 | External acknowledge that the output byte was taken |
| irq | output | 1 | Level interrupt request |

## Verification
Register writes, flag changes from strobes, and side effects of reads take effect at the clock edge that ends the access. The bench compares pin_out, pin_oe and irq with its reference model half a cycle after each edge. A pin change becomes readable only after two edges, so the bench reads at zero, one and two edges after the change and expects the old value twice and then the new one. Read data is combinational, so it is sampled one time unit after the access is driven, before the edge that applies the read's side effect.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int PORT_W = 8;
  localparam int IDX_W  = $clog2(PORT_W);

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_MODE = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic empty_irq_en;
    logic full_irq_en;
    logic out_latched;
    logic in_latched;
  } mode_t;

  function automatic logic [PORT_W-1:0] put_bit(logic [PORT_W-1:0] word,
                                                logic [IDX_W-1:0]  idx,
                                                logic              val);
    logic [PORT_W-1:0] r;
    r      = word;
    r[idx] = val;
    return r;
  endfunction

  function automatic logic irq_level(logic full, logic empty, mode_t m);
    return (full & m.full_irq_en) | (empty & m.empty_irq_en);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/gpio_mbox_flags.sv
module gpio_mbox_flags #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_latched,
  input  logic             out_latched,
  input  logic             cap_stb,
  input  logic             data_rd,
  input  logic             data_wr,
  input  logic             take_ack,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] hold,
  output logic             full,
  output logic             empty,
  output logic             capture_evt,
  output logic             drain_evt,
  output logic             fill_evt,
  output logic             taken_evt
);

  assign capture_evt = in_latched  & cap_stb;
  assign drain_evt   = in_latched  & data_rd;
  assign fill_evt    = out_latched & data_wr;
  assign taken_evt   = out_latched & take_ack;

  // Input side: a capture takes precedence over a drain in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      hold <= '0;
    end else if (capture_evt) begin
      full <= 1'b1;
      hold <= din;
    end else if (drain_evt) begin
      full <= 1'b0;
    end
  end

  // Output side: a new write takes precedence over an acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         empty <= 1'b1;
    else if (fill_evt)  empty <= 1'b0;
    else if (taken_evt) empty <= 1'b1;
  end

endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_wr_out,
  input  logic              byte_wr_dir,
  input  logic              bit_wr,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] out_q,
  output logic [PORT_W-1:0] dir_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (byte_wr_out) begin
      out_q <= wdata;
    end else if (bit_wr) begin
      out_q <= put_bit(out_q, bit_idx, wdata[0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (byte_wr_dir) begin
      dir_q <= wdata;
    end else if (bit_wr) begin
      dir_q <= put_bit(dir_q, bit_idx, wdata[1]);
    end
  end

endmodule

// File: rtl/gpio_mailbox_port.sv
module gpio_mailbox_port
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  input  logic              cap_stb,
  input  logic              take_ack,
  output logic              irq
);

  localparam int OFF_W = ADDR_W - 1;

  // Address decode: top address bit selects the per-pin window.
  logic              bit_region;
  logic [OFF_W-1:0]  reg_off;
  logic [IDX_W-1:0]  bit_idx;
  logic              bus_rd, bus_we;
  logic              hit_data, hit_dir, hit_mode, hit_stat;

  assign bit_region = bus_addr[ADDR_W-1];
  assign reg_off    = bus_addr[OFF_W-1:0];
  assign bit_idx    = bus_addr[IDX_W-1:0];
  assign bus_rd     = bus_sel & ~bus_wr;
  assign bus_we     = bus_sel &  bus_wr;
  assign hit_data   = ~bit_region & (reg_off == OFF_W'(REG_DATA));
  assign hit_dir    = ~bit_region & (reg_off == OFF_W'(REG_DIR));
  assign hit_mode   = ~bit_region & (reg_off == OFF_W'(REG_MODE));
  assign hit_stat   = ~bit_region & (reg_off == OFF_W'(REG_STAT));

  // Named events used by the bound checker.
  logic data_rd_evt, data_wr_evt, dir_wr_evt, mode_wr_evt, bit_wr_evt;
  assign data_rd_evt = bus_rd & hit_data;
  assign data_wr_evt = bus_we & hit_data;
  assign dir_wr_evt  = bus_we & hit_dir;
  assign mode_wr_evt = bus_we & hit_mode;
  assign bit_wr_evt  = bus_we & bit_region;

  mode_t mode_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mode_q <= '0;
    else if (mode_wr_evt) mode_q <= mode_t'(bus_wdata[$bits(mode_t)-1:0]);
  end

  logic [PORT_W-1:0] pin_sync;
  gpio_in_sync #(
    .WIDTH  (PORT_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_in),
    .dout  (pin_sync)
  );

  gpio_pin_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_wr_out (data_wr_evt),
    .byte_wr_dir (dir_wr_evt),
    .bit_wr      (bit_wr_evt),
    .bit_idx     (bit_idx),
    .wdata       (bus_wdata),
    .out_q       (pin_out),
    .dir_q       (pin_oe)
  );

  logic [PORT_W-1:0] hold_byte;
  logic full, empty;
  logic capture_evt, drain_evt, fill_evt, taken_evt;

  gpio_mbox_flags #(
    .WIDTH (PORT_W)
  ) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_latched  (mode_q.in_latched),
    .out_latched (mode_q.out_latched),
    .cap_stb     (cap_stb),
    .data_rd     (data_rd_evt),
    .data_wr     (data_wr_evt),
    .take_ack    (take_ack),
    .din         (pin_sync),
    .hold        (hold_byte),
    .full        (full),
    .empty       (empty),
    .capture_evt (capture_evt),
    .drain_evt   (drain_evt),
    .fill_evt    (fill_evt),
    .taken_evt   (taken_evt)
  );

  assign irq = irq_level(full, empty, mode_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bit_region) begin
        bus_rdata[1] = pin_oe[bit_idx];
        bus_rdata[0] = pin_sync[bit_idx];
      end else if (hit_data) begin
        bus_rdata = mode_q.in_latched ? hold_byte : pin_sync;
      end else if (hit_dir) begin
        bus_rdata = pin_oe;
      end else if (hit_mode) begin
        bus_rdata[$bits(mode_t)-1:0] = mode_q;
      end else if (hit_stat) begin
        bus_rdata[2:0] = {irq, empty, full};
      end
    end
  end

endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker
  import gpio_port_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              capture_evt,
  input logic              drain_evt,
  input logic              fill_evt,
  input logic              taken_evt,
  input logic              data_wr_evt,
  input logic              bit_wr_evt,
  input logic [IDX_W-1:0]  bit_idx,
  input logic [PORT_W-1:0] wdata,
  input logic [PORT_W-1:0] pin_out,
  input logic              in_latched,
  input logic              full,
  input logic              empty,
  input logic              full_en,
  input logic              empty_en,
  input logic              irq
);

  assert_byte_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_evt |=> pin_out == $past(wdata));

  assert_bit_keeps_others_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_wr_evt |=> ((pin_out ^ $past(pin_out)) & ~(PORT_W'(1) << $past(bit_idx))) == '0);

  assert_transparent_no_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_latched && !full) |=> !full);

  assert_capture_sets_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> full);

  assert_drain_clears_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_evt && !capture_evt) |=> !full);

  assert_fill_clears_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> !empty);

  assert_take_sets_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_evt && !fill_evt) |=> empty);

  assert_irq_from_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && full_en) |-> irq);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(full && full_en) && !(empty && empty_en)) |-> !irq);

endmodule

bind gpio_mailbox_port gpio_port_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .capture_evt (capture_evt),
  .drain_evt   (drain_evt),
  .fill_evt    (fill_evt),
  .taken_evt   (taken_evt),
  .data_wr_evt (data_wr_evt),
  .bit_wr_evt  (bit_wr_evt),
  .bit_idx     (bit_idx),
  .wdata       (bus_wdata),
  .pin_out     (pin_out),
  .in_latched  (mode_q.in_latched),
  .full        (full),
  .empty       (empty),
  .full_en     (mode_q.full_irq_en),
  .empty_en    (mode_q.empty_irq_en),
  .irq         (irq)
);

// File: tb/sim_gpio_mailbox_port.sv
`timescale 1ns/1ps
module sim_gpio_mailbox_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, bus_rdata;
  logic [7:0] pin_in = '0, pin_out, pin_oe;
  logic       cap_stb = 1'b0, take_ack = 1'b0, irq;

  always #4 clk = ~clk;

  gpio_mailbox_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(bus_wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .cap_stb(cap_stb), .take_ack(take_ack), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] last_rdata;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model: a history queue stands in for the synchroniser.
  logic [7:0] m_out = '0, m_dir = '0, m_hold = '0;
  logic       m_full = 1'b0, m_empty = 1'b1;
  logic [3:0] m_mode = '0;
  logic [7:0] hist[$] = '{8'h00, 8'h00};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = '0; m_dir = '0; m_hold = '0;
      m_full = 1'b0; m_empty = 1'b1; m_mode = '0;
      hist = '{8'h00, 8'h00};
    end else begin
      if (m_mode[0] && cap_stb) begin
        m_full = 1'b1; m_hold = hist[0];
      end else if (m_mode[0] && sel && !bus_wr && addr == 4'h0) begin
        m_full = 1'b0;
      end
      if (m_mode[1] && sel && bus_wr && addr == 4'h0) m_empty = 1'b0;
      else if (m_mode[1] && take_ack)                 m_empty = 1'b1;
      if (sel && bus_wr) begin
        if (addr == 4'h0)      m_out = wdata;
        else if (addr == 4'h1) m_dir = wdata;
        else if (addr == 4'h2) m_mode = wdata[3:0];
        else if (addr >= 4'h8) begin
          m_out[addr - 4'h8] = wdata[0];
          m_dir[addr - 4'h8] = wdata[1];
        end
      end
      hist.push_back(pin_in);
      void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 pin_out vs model", pin_out, m_out);
      check("R2 pin_oe vs model", pin_oe, m_dir);
      check("R9 irq vs model", {7'b0, irq},
            {7'b0, (m_full & m_mode[2]) | (m_empty & m_mode[3])});
    end
  end

  task automatic bus_cycle(logic w, logic [3:0] a, logic [7:0] d, logic stb, logic ack);
    sel = 1'b1; bus_wr = w; addr = a; wdata = d; cap_stb = stb; take_ack = ack;
    #1 last_rdata = bus_rdata;
    @(negedge clk);
    sel = 1'b0; bus_wr = 1'b0; cap_stb = 1'b0; take_ack = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    bus_cycle(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] exp, string tag, logic stb = 1'b0);
    bus_cycle(1'b0, a, 8'h00, stb, 1'b0);
    check(tag, last_rdata, exp);
  endtask

  task automatic pulse_stb();
    cap_stb = 1'b1; @(negedge clk); cap_stb = 1'b0;
  endtask

  task automatic pulse_ack();
    take_ack = 1'b1; @(negedge clk); take_ack = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 pin_out reset", pin_out, 8'h00);
    check("R1 pin_oe reset", pin_oe, 8'h00);
    check("R1 irq reset", {7'b0, irq}, 8'h00);
    rd(4'h3, 8'h02, "R1 status after reset");
    rd(4'h2, 8'h00, "R1 mode after reset");
    rd(4'h1, 8'h00, "R1 direction after reset");

    // R2 byte writes
    wr(4'h0, 8'hA5);
    wr(4'h1, 8'h0F);
    check("R2 byte data", pin_out, 8'hA5);
    check("R2 byte direction", pin_oe, 8'h0F);

    // R3 bit writes and reads
    wr(4'hE, 8'h03);
    check("R3 bit6 set out", pin_out, 8'hE5);
    check("R3 bit6 set dir", pin_oe, 8'h4F);
    wr(4'h8, 8'h00);
    check("R3 bit0 clear out", pin_out, 8'hE4);
    check("R3 bit0 clear dir", pin_oe, 8'h4E);
    rd(4'hE, 8'h02, "R3 bit6 read");

    // R4 transparent input latency and ignored strobe
    pin_in = 8'h3C;
    rd(4'h0, 8'h00, "R4 zero edges");
    rd(4'h0, 8'h00, "R4 one edge");
    rd(4'h0, 8'h3C, "R4 two edges");
    pulse_stb();
    rd(4'h3, 8'h02, "R4 strobe ignored");

    // R5 latched capture
    wr(4'h2, 8'h01);
    pin_in = 8'h96;
    repeat (3) @(negedge clk);
    pulse_stb();
    pin_in = 8'h11;
    rd(4'h3, 8'h03, "R5 full after capture");
    rd(4'h0, 8'h96, "R5 held byte");
    rd(4'h3, 8'h02, "R6 full cleared by read");

    // R6 strobe in the same cycle as a read
    rd(4'h0, 8'h96, "R6 read with strobe", 1'b1);
    rd(4'h3, 8'h03, "R6 strobe wins");
    rd(4'h0, 8'h11, "R6 new byte held");
    rd(4'h3, 8'h02, "R6 drained again");

    // R7 latched output
    wr(4'h2, 8'h02);
    wr(4'h0, 8'h5A);
    rd(4'h3, 8'h00, "R7 write clears empty");
    pulse_ack();
    rd(4'h3, 8'h02, "R7 ack sets empty");
    bus_cycle(1'b1, 4'h0, 8'hC3, 1'b0, 1'b1);
    rd(4'h3, 8'h00, "R7 write beats ack");
    pulse_ack();
    rd(4'h3, 8'h02, "R7 ack after collision");
    wr(4'h2, 8'h00);
    wr(4'h0, 8'h77);
    rd(4'h3, 8'h02, "R7 transparent write leaves empty");
    check("R7 transparent output", pin_out, 8'h77);

    // R8 readback, R9 interrupt
    wr(4'h2, 8'h0C);
    rd(4'h2, 8'h0C, "R8 mode readback");
    rd(4'h3, 8'h06, "R8 status with irq");
    check("R9 irq from empty", {7'b0, irq}, 8'h01);
    wr(4'h2, 8'h0A);
    wr(4'h0, 8'h33);
    check("R9 irq drops on fill", {7'b0, irq}, 8'h00);
    pulse_ack();
    check("R9 irq on take", {7'b0, irq}, 8'h01);
    wr(4'h2, 8'h05);
    check("R9 irq off with empty disabled", {7'b0, irq}, 8'h00);
    pulse_stb();
    check("R9 irq from full", {7'b0, irq}, 8'h01);
    rd(4'h0, 8'h11, "R5 capture in irq mode");
    check("R9 irq drops on drain", {7'b0, irq}, 8'h00);
    rd(4'h3, 8'h02, "R8 final status");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule